// File: doc/BRIEF.md
# Dual-Path Floating-Point Adder

This block adds or subtracts two IEEE-754 single-precision numbers in a fixed-latency pipeline that accepts one operation every clock. Each operation is sorted early by the kind of work it needs. An effective subtraction of operands whose exponents differ by at most one can cancel many leading bits, so it goes down a near path. That path subtracts without any alignment loss, counts leading zeros and shifts left. Every other operation goes down a far path. There the larger-magnitude operand is placed first, the smaller one is right-shifted with guard, round and sticky bits kept, and the two are added. A last stage picks one of the two results, rounds it to nearest-even and packs it.

Both paths run in parallel on every operation, and the choice between them is made only at the end. Denormal inputs and outputs, signed zeros, infinities and NaNs are all handled. Round-to-nearest-even is the only rounding mode, and no exception flags are produced.

Top module: `fpadd_dual`

## Requirements
- R1: `in_ready` is high whenever `rst` is low. An operation accepted on a rising edge (`in_valid` and `in_ready` both high) produces `out_valid` high, with its result, after exactly four rising edges. Operations may be accepted on consecutive edges and come out in order, one per cycle.
- R2: While `rst` is high, `in_ready`, `out_valid` and `out_result` are low, and an operation offered during reset never produces an output.
- R3: Operands and results use the single-precision layout: sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0. Finite results equal the exact sum rounded to nearest, with ties going to the even significand.
- R4: An effective subtraction with an exponent difference of 0 or 1 returns the exact normalized difference, even when most leading bits cancel.
- R5: Denormal operands are accepted. Results too small for a normal exponent come out denormal (exponent field 0), and denormal sums that reach 2^-126 come out as normal numbers.
- R6: x − x and x + (−x) give +0 for finite x. (+0)+(+0) gives +0, (−0)+(−0) gives −0, and a sum of zeros with opposite signs gives +0.
- R7: A NaN operand, or infinities of opposite effective sign, gives the quiet NaN 0x7FC00000, and no other NaN encoding is ever produced.
- R8: An infinity combined with a finite value gives that infinity, with its effective sign. Two infinities of the same effective sign give that infinity.
- R9: A finite result whose rounded magnitude reaches 2^128 gives an infinity with the result's sign (exponent field 0xFF, fraction 0).
- R10: `in_sub` high computes `in_a − in_b`, which is `in_a` plus `in_b` with its sign bit inverted. `in_sub` low computes `in_a + in_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_sub | input | 1 | 1 subtracts `in_b`, 0 adds it |
| out_valid | output | 1 | `out_result` holds a finished result |
| out_result | output | 32 | Rounded sum or difference |

## Verification
Because the latency is fixed, any fault in a pipeline register or in the path-select bit shows up exactly four edges after the offending operation. It appears as a wrong word or a valid pulse in the wrong cycle, and a scoreboard that records the expected return cycle catches it. A near path whose leading-zero shift is not clamped at the minimum exponent corrupts denormal differences. Guard, round and sticky bits that are lost on the far path appear as off-by-one-ulp results on tie and just-above-tie cases. A wrong swap or a wrong sign shows up as a flipped sign bit on subtractions whose second operand is larger. Directed cases aim at each of these, and a long stream of random operations, biased towards close exponents and denormals, is compared against an exact wide-integer model in the bench.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;          // significand with hidden bit
    localparam int NEAR_W  = SIG_W + 1;           // one extra bit for a 1-step offset
    localparam int FAR_W   = SIG_W + 4;           // three exact low bits plus sticky
    localparam int MANT_W  = SIG_W + 3;           // significand, guard, round, sticky
    localparam int EXPI_W  = EXP_W + 2;           // internal exponent with headroom
    localparam int ALN_W   = SIG_W + 26;          // alignment shifter width
    localparam int SHC_W   = 5;                   // capped alignment distance width
    localparam int LZC_W   = $clog2(NEAR_W + 1);

    localparam logic [EXP_W-1:0]  EXP_MAX = '1;
    localparam logic [WORD_W-1:0] QNAN    = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;      // sign of the larger-magnitude operand
        logic              eff_sub;   // signs differ after applying the operation
        logic              near;      // near path chosen
        logic              special;   // result fixed by NaN / infinity rules
        logic [WORD_W-1:0] spec_val;
    } ctl_t;

    typedef struct packed {
        ctl_t              ctl;
        logic [EXPI_W-1:0] exp_l;     // effective exponent of larger operand
        logic [SIG_W-1:0]  sig_l;
        logic [SIG_W-1:0]  sig_s;
        logic [EXP_W-1:0]  dexp;      // exponent distance, never negative
    } unp_t;

    typedef struct packed {
        logic [EXPI_W-1:0] exp;
        logic [MANT_W-1:0] mant;      // [MANT_W-1] set means normal
    } norm_t;

    function automatic logic [LZC_W-1:0] lead_zeros(input logic [NEAR_W-1:0] v);
        logic [LZC_W-1:0] n;
        n = LZC_W'(NEAR_W);
        for (int i = 0; i < NEAR_W; i++)
            if (v[i]) n = LZC_W'(NEAR_W - 1 - i);
        return n;
    endfunction

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              op_sub,
    output unp_t              unp
);
    logic [EXP_W-1:0]  ea, eb, ea_eff, eb_eff, e_l, e_s;
    logic [FRAC_W-1:0] fa, fb;
    logic [SIG_W-1:0]  sa_sig, sb_sig;
    logic              sgn_a, sgn_b, swap, eff_sub;
    logic              a_nan, b_nan, a_inf, b_inf, res_nan;
    logic              big_sign;

    always_comb begin
        ea     = op_a[WORD_W-2 -: EXP_W];
        eb     = op_b[WORD_W-2 -: EXP_W];
        fa     = op_a[FRAC_W-1:0];
        fb     = op_b[FRAC_W-1:0];
        sgn_a  = op_a[WORD_W-1];
        sgn_b  = op_b[WORD_W-1] ^ op_sub;
        eff_sub = sgn_a ^ sgn_b;

        ea_eff = (ea == '0) ? EXP_W'(1) : ea;
        eb_eff = (eb == '0) ? EXP_W'(1) : eb;
        sa_sig = {(ea != '0), fa};
        sb_sig = {(eb != '0), fb};

        a_nan  = (ea == EXP_MAX) && (fa != '0);
        b_nan  = (eb == EXP_MAX) && (fb != '0);
        a_inf  = (ea == EXP_MAX) && (fa == '0);
        b_inf  = (eb == EXP_MAX) && (fb == '0);
        res_nan = a_nan || b_nan || (a_inf && b_inf && eff_sub);

        // larger magnitude first; ties keep operand a first
        swap     = op_b[WORD_W-2:0] > op_a[WORD_W-2:0];
        e_l      = swap ? eb_eff : ea_eff;
        e_s      = swap ? ea_eff : eb_eff;
        big_sign = swap ? sgn_b : sgn_a;

        unp.exp_l = EXPI_W'(e_l);
        unp.sig_l = swap ? sb_sig : sa_sig;
        unp.sig_s = swap ? sa_sig : sb_sig;
        unp.dexp  = e_l - e_s;

        unp.ctl.sign     = big_sign;
        unp.ctl.eff_sub  = eff_sub;
        unp.ctl.near     = eff_sub && (unp.dexp <= EXP_W'(1));
        unp.ctl.special  = res_nan || a_inf || b_inf;
        unp.ctl.spec_val = res_nan ? QNAN : {big_sign, EXP_MAX, {FRAC_W{1'b0}}};
    end
endmodule

// File: rtl/fpadd_near.sv
module fpadd_near
    import fpadd_pkg::*;
(
    input  logic              clk,
    input  logic [SIG_W-1:0]  sig_l,
    input  logic [SIG_W-1:0]  sig_s,
    input  logic              dist_one,
    input  logic [EXPI_W-1:0] exp_l,
    output norm_t             res
);
    // stage A: both alignments formed, the one selected by the distance is subtracted
    logic [NEAR_W-1:0] l_ext, s_d0, s_d1, diff_q;
    logic [EXPI_W-1:0] exp_q;

    always_comb begin
        l_ext = {sig_l, 1'b0};
        s_d0  = {sig_s, 1'b0};
        s_d1  = {1'b0, sig_s};
    end

    always_ff @(posedge clk) begin
        diff_q <= l_ext - (dist_one ? s_d1 : s_d0);
        exp_q  <= exp_l;
    end

    // stage B: leading-zero count, shift clamped at the minimum exponent
    logic [LZC_W-1:0]  lz;
    logic [EXPI_W-1:0] lim, sh;
    logic [NEAR_W-1:0] shifted;

    always_comb begin
        lz      = lead_zeros(diff_q);
        lim     = exp_q - EXPI_W'(1);
        sh      = (EXPI_W'(lz) > lim) ? lim : EXPI_W'(lz);
        shifted = diff_q << sh;
    end

    always_ff @(posedge clk) begin
        res.mant <= {shifted, 2'b00};
        res.exp  <= exp_q - sh;
    end
endmodule

// File: rtl/fpadd_far.sv
module fpadd_far
    import fpadd_pkg::*;
(
    input  logic              clk,
    input  logic [SIG_W-1:0]  sig_l,
    input  logic [SIG_W-1:0]  sig_s,
    input  logic [EXP_W-1:0]  dexp,
    input  logic              eff_sub,
    input  logic [EXPI_W-1:0] exp_l,
    output norm_t             res
);
    localparam int LOW_W = ALN_W - (FAR_W - 1);

    // stage A: align the smaller operand, then add or subtract
    logic [SHC_W-1:0]  dcap;
    logic [ALN_W-1:0]  aligned;
    logic [FAR_W-1:0]  l_w, s_w;
    logic [FAR_W:0]    sum_q;
    logic              sub_q;
    logic [EXPI_W-1:0] exp_q;

    always_comb begin
        dcap    = (dexp > EXP_W'((1 << SHC_W) - 1)) ? '1 : dexp[SHC_W-1:0];
        aligned = {sig_s, {(ALN_W-SIG_W){1'b0}}} >> dcap;
        l_w     = {sig_l, 4'b0000};
        s_w     = {aligned[ALN_W-1 -: FAR_W-1], |aligned[LOW_W-1:0]};
    end

    always_ff @(posedge clk) begin
        sum_q <= eff_sub ? {1'b0, l_w - s_w} : ({1'b0, l_w} + {1'b0, s_w});
        sub_q <= eff_sub;
        exp_q <= exp_l;
    end

    // stage B: one-position normalization in either direction
    norm_t nxt;
    always_comb begin
        if (!sub_q) begin
            if (sum_q[FAR_W]) begin
                nxt.mant = {sum_q[FAR_W -: MANT_W-1], |sum_q[2:0]};
                nxt.exp  = exp_q + EXPI_W'(1);
            end else begin
                nxt.mant = {sum_q[FAR_W-1 -: MANT_W-1], |sum_q[1:0]};
                nxt.exp  = exp_q;
            end
        end else begin
            if (sum_q[FAR_W-1]) begin
                nxt.mant = {sum_q[FAR_W-1 -: MANT_W-1], |sum_q[1:0]};
                nxt.exp  = exp_q;
            end else begin
                nxt.mant = {sum_q[FAR_W-2 -: MANT_W-1], sum_q[0]};
                nxt.exp  = exp_q - EXPI_W'(1);
            end
        end
    end

    always_ff @(posedge clk) res <= nxt;
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
    import fpadd_pkg::*;
(
    input  norm_t             val,
    input  logic              sign,
    input  logic              eff_sub,
    input  logic              special,
    input  logic [WORD_W-1:0] spec_val,
    output logic [WORD_W-1:0] result
);
    logic              lsb, grd, rest, up;
    logic [SIG_W:0]    inc;
    logic [SIG_W-1:0]  sig;
    logic [EXPI_W-1:0] e;
    logic [EXP_W-1:0]  efield;

    always_comb begin
        lsb  = val.mant[3];
        grd  = val.mant[2];
        rest = val.mant[1] | val.mant[0];
        up   = grd & (rest | lsb);
        inc  = {1'b0, val.mant[MANT_W-1:3]} + (SIG_W+1)'(up);
        if (inc[SIG_W]) begin
            sig = inc[SIG_W:1];
            e   = val.exp + EXPI_W'(1);
        end else begin
            sig = inc[SIG_W-1:0];
            e   = val.exp;
        end
        efield = sig[SIG_W-1] ? e[EXP_W-1:0] : '0;

        if (special)
            result = spec_val;
        else if (val.mant == '0)
            result = {sign & ~eff_sub, {(WORD_W-1){1'b0}}};
        else if (sig[SIG_W-1] && (e >= EXPI_W'(EXP_MAX)))
            result = {sign, EXP_MAX, {FRAC_W{1'b0}}};
        else
            result = {sign, efield, sig[FRAC_W-1:0]};
    end
endmodule

// File: rtl/fpadd_dual.sv
module fpadd_dual
    import fpadd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    input  logic        in_sub,
    output logic        out_valid,
    output logic [31:0] out_result
);
    localparam int DEPTH = 3;   // control stages ahead of the output register

    unp_t              unp_c, s1;
    ctl_t              ctl2, ctl3;
    logic [DEPTH-1:0]  vld;
    norm_t             near_r, far_r, pick;
    logic [WORD_W-1:0] rnd;

    assign in_ready = ~rst;

    fpadd_unpack u_unpack (
        .op_a  (in_a),
        .op_b  (in_b),
        .op_sub(in_sub),
        .unp   (unp_c)
    );

    always_ff @(posedge clk) begin
        s1   <= unp_c;
        ctl2 <= s1.ctl;
        ctl3 <= ctl2;
        if (rst) vld <= '0;
        else     vld <= {vld[DEPTH-2:0], in_valid & in_ready};
    end

    fpadd_near u_near (
        .clk     (clk),
        .sig_l   (s1.sig_l),
        .sig_s   (s1.sig_s),
        .dist_one(s1.dexp[0]),
        .exp_l   (s1.exp_l),
        .res     (near_r)
    );

    fpadd_far u_far (
        .clk    (clk),
        .sig_l  (s1.sig_l),
        .sig_s  (s1.sig_s),
        .dexp   (s1.dexp),
        .eff_sub(s1.ctl.eff_sub),
        .exp_l  (s1.exp_l),
        .res    (far_r)
    );

    assign pick = ctl3.near ? near_r : far_r;

    fpadd_round u_round (
        .val     (pick),
        .sign    (ctl3.sign),
        .eff_sub (ctl3.eff_sub),
        .special (ctl3.special),
        .spec_val(ctl3.spec_val),
        .result  (rnd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= vld[DEPTH-1];
            out_result <= rnd;
        end
    end
endmodule

// File: rtl/fpadd_dual_chk.sv
module fpadd_dual_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_a,
    input logic [31:0] in_b,
    input logic        in_sub,
    input logic        out_valid,
    input logic [31:0] out_result
);
    // R1: a result appears exactly four edges after each accepted operation
    a_r1_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid && in_ready, 4));

    // R7: NaN operands give the single quiet NaN
    a_r7_nan_operand: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_ready &&
              ((in_a[30:23] == 8'hFF && in_a[22:0] != 0) ||
               (in_b[30:23] == 8'hFF && in_b[22:0] != 0)), 4)
        |-> (out_valid && out_result == 32'h7FC00000));

    // R7: no NaN other than the quiet one leaves the block
    a_r7_nan_form: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_result[30:23] == 8'hFF && out_result[22:0] != 0)
        |-> out_result == 32'h7FC00000);

    // R6: subtracting a finite value from itself gives +0
    a_r6_self_cancel: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_ready && in_sub && in_a == in_b && in_a[30:23] != 8'hFF, 4)
        |-> out_result == 32'h0);

    // R8: an infinite first operand with a finite second one passes through
    a_r8_inf_pass: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_ready && in_a[30:0] == 31'h7F800000 && in_b[30:23] != 8'hFF, 4)
        |-> out_result == $past(in_a, 4));
endmodule

bind fpadd_dual fpadd_dual_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_sub    (in_sub),
    .out_valid (out_valid),
    .out_result(out_result)
);

// File: tb/test_fpadd_dual.sv
`timescale 1ns/1ps
module test_fpadd_dual;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        in_sub = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;

    fpadd_dual i_fpadd_dual (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
        .out_valid(out_valid), .out_result(out_result)
    );

    always #2 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    int    tx       = 0;
    int    rx       = 0;
    bit    done     = 0;
    logic [31:0] exp_res [0:1023];
    int          exp_cyc [0:1023];
    string       exp_tag [0:1023];

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    // scoreboard: value and return cycle of every result
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rx >= tx) begin
                check("R1 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                check(exp_tag[rx], out_result, exp_res[rx]);
                check("R1 latency", 32'(cyc), 32'(exp_cyc[rx]));
                rx++;
            end
        end
    end

    // exact wide-integer model of a correctly rounded single-precision sum
    function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic sub);
        logic sa, sb, s, half, stk, up;
        logic [7:0] ea, eb;
        logic [22:0] fa, fb;
        logic [299:0] A, B, mag, q, mask;
        int ia, ib, emin, p, k, E;
        sa = a[31]; sb = b[31] ^ sub;
        ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
        if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0)) return 32'h7FC00000;
        if (ea == 8'hFF && eb == 8'hFF) return (sa == sb) ? {sa, 8'hFF, 23'h0} : 32'h7FC00000;
        if (ea == 8'hFF) return {sa, 8'hFF, 23'h0};
        if (eb == 8'hFF) return {sb, 8'hFF, 23'h0};
        ia = (ea == 0) ? 1 : int'(ea);
        ib = (eb == 0) ? 1 : int'(eb);
        emin = (ia < ib) ? ia : ib;
        A = {276'b0, (ea != 0), fa} << (ia - emin);
        B = {276'b0, (eb != 0), fb} << (ib - emin);
        if (sa == sb)    begin mag = A + B; s = sa; end
        else if (A >= B) begin mag = A - B; s = sa; end
        else             begin mag = B - A; s = sb; end
        if (mag == 0) return {(sa == sb) ? sa : 1'b0, 31'h0};
        p = 0;
        for (int i = 0; i < 300; i++) if (mag[i]) p = i;
        E = p + emin - 23;
        if (E < 1) E = 1;
        k = E - emin;
        if (k <= 0) begin
            q = mag << (-k); half = 1'b0; stk = 1'b0;
        end else begin
            q = mag >> k;
            half = mag[k-1];
            mask = (300'b1 << (k - 1)) - 300'b1;
            stk = |(mag & mask);
        end
        up = half & (stk | q[0]);
        q = q + {299'b0, up};
        if (q[24]) begin q = q >> 1; E++; end
        if (E >= 255) return {s, 8'hFF, 23'h0};
        return {s, q[23] ? E[7:0] : 8'h00, q[22:0]};
    endfunction

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic sub,
                        input logic [31:0] want, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_sub = sub;
        exp_res[tx] = want;
        exp_cyc[tx] = cyc + 4;
        exp_tag[tx] = tag;
        tx++;
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        while (rx != tx) @(negedge clk);
    endtask

    task automatic t_reset();
        in_valid = 1'b1; in_a = 32'h3F800000; in_b = 32'h3F800000;
        repeat (3) @(negedge clk);
        check("R2 in_ready in reset", {31'b0, in_ready}, 32'd0);
        check("R2 out_valid in reset", {31'b0, out_valid}, 32'd0);
        check("R2 out_result in reset", out_result, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 in_ready after reset", {31'b0, in_ready}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R2 no output from reset-time offer", {31'b0, out_valid}, 32'd0);
        end
    endtask

    task automatic t_rounding();
        send(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, "R3 1+1");
        send(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, "R3 tie to even down");
        send(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, "R3 tie to even up");
        send(32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, "R3 above half");
        drain();
    endtask

    task automatic t_near();
        send(32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, "R4 deep cancel d=1");
        send(32'h3FC00000, 32'h3FA00000, 1'b1, 32'h3E800000, "R4 d=0");
        send(32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, "R4 one-ulp difference");
        drain();
    endtask

    task automatic t_sub_op();
        send(32'h40000000, 32'h40400000, 1'b1, 32'hBF800000, "R10 2-3");
        send(32'h40000000, 32'hC0400000, 1'b0, 32'hBF800000, "R10 2+(-3)");
        send(32'h40A00000, 32'hC0400000, 1'b1, 32'h41000000, "R10 5-(-3)");
        drain();
    endtask

    task automatic t_denormal();
        send(32'h00000001, 32'h00000001, 1'b0, 32'h00000002, "R5 tiny sum");
        send(32'h00400000, 32'h00400000, 1'b0, 32'h00800000, "R5 denormals to normal");
        send(32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF, "R5 normal to denormal");
        send(32'h01000000, 32'h00800000, 1'b1, 32'h00800000, "R5 near to min normal");
        send(32'h00C00000, 32'h00BFFFFF, 1'b1, 32'h00000001, "R5 near clamp");
        drain();
    endtask

    task automatic t_zeros();
        send(32'h40400000, 32'h40400000, 1'b1, 32'h00000000, "R6 x-x");
        send(32'hC0400000, 32'h40400000, 1'b0, 32'h00000000, "R6 -x+x");
        send(32'h00000000, 32'h00000000, 1'b0, 32'h00000000, "R6 +0++0");
        send(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, "R6 -0+-0");
        send(32'h80000000, 32'h00000000, 1'b0, 32'h00000000, "R6 -0++0");
        send(32'h80000000, 32'h00000000, 1'b1, 32'h80000000, "R6 -0-+0");
        drain();
    endtask

    task automatic t_specials();
        send(32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000, "R7 signalling NaN");
        send(32'h3F800000, 32'hFFC00000, 1'b0, 32'h7FC00000, "R7 NaN in b");
        send(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, "R7 inf-inf");
        send(32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, "R7 inf+-inf");
        send(32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, "R8 inf+1");
        send(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, "R8 1-inf");
        send(32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000, "R8 -inf+-inf");
        drain();
    endtask

    task automatic t_overflow();
        send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, "R9 max+max");
        send(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, "R9 -max-max");
        send(32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, "R9 tie rounds past max");
        send(32'h7F7FFFFF, 32'h72FFFFFF, 1'b0, 32'h7F7FFFFF, "R9 below tie stays max");
        drain();
    endtask

    task automatic t_stream();
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            logic [7:0] eb;
            logic sub;
            int mode;
            a = $urandom; b = $urandom; sub = $urandom_range(0, 1);
            mode = $urandom_range(0, 3);
            if (mode == 1) begin
                eb = a[30:23] + 8'($urandom_range(0, 2));
                if (eb == 8'hFF) eb = 8'hFE;
                b[30:23] = eb;
            end else if (mode == 2) begin
                a[30:23] = 8'($urandom_range(0, 2));
                b[30:23] = 8'($urandom_range(0, 2));
            end else if (mode == 3) begin
                b = {~a[31] ^ sub ^ 1'b1, a[30:23], a[22:0] ^ 23'($urandom_range(0, 15))};
            end
            send(a, b, sub, ref_add(a, b, sub), "R3 stream vs exact model");
        end
        drain();
    endtask

    initial begin
        t_reset();
        t_rounding();
        t_near();
        t_sub_op();
        t_denormal();
        t_zeros();
        t_specials();
        t_overflow();
        t_stream();
        done = 1;
        finish_run();
    end
endmodule